// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps events on two asynchronous input pins. Each pin is brought into the clock domain by a short synchronizer chain. Its synchronized level is then compared with the previous sample to find rising and falling transitions. A per-channel 2-bit mode decides which transitions count. When a counted transition is seen, the free-running counter value supplied from outside is stored in that channel's capture register, and the channel's event flag is raised.

Flags stay set until software clears them with a write-one strobe. A per-channel enable decides whether a flag contributes to the single combined interrupt line. The counter itself and the register bus sit outside the block. Index 0 of every per-channel port is channel 1 and index 1 is channel 2.

Top module: `edgeCaptureUnit`

## Requirements
- R1: After reset both capture registers read 0, both flags are 0 and the interrupt is 0.
- R2: Mode 1 (rising) captures on a low-to-high pin transition only; a high-to-low transition leaves the register and the flag unchanged.
- R3: Mode 2 (falling) captures on a high-to-low pin transition only; a low-to-high transition leaves the register and the flag unchanged.
- R4: Mode 3 (both) captures on every pin transition in either direction.
- R5: Mode 0 (disabled) never captures: the flag stays 0 and the register keeps its last captured value.
- R6: The mode input packs channel 1 in bits [1:0] and channel 2 in bits [3:2]; a mode on one channel does not enable captures on the other.
- R7: The capture register and flag update on the third rising clock edge after the pin changes (two synchronizer stages, then the edge). The stored value is the counter input present just before that edge.
- R8: A capture sets the channel flag. A 1 on the channel's clear strobe clears it on the next clock edge. If a capture and a clear coincide, the flag stays set.
- R9: A capture while the flag is already set overwrites the register with the new counter value and leaves the flag set.
- R10: The interrupt output is high exactly when some channel has both its flag and its interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| capPin | input | 2 | Asynchronous event pins, bit 0 = channel 1 |
| counterVal | input | CNT_W (32) | Running counter value to be captured |
| modeSel | input | 4 | Edge mode per channel, 2 bits each, channel 1 in [1:0] |
| flagClr | input | 2 | Write-one-to-clear strobes for the flags |
| irqEn | input | 2 | Per-channel interrupt enables |
| capVal | output | 2*CNT_W (64) | Capture registers, channel 1 in the low word |
| capFlag | output | 2 | Per-channel capture flags |
| irq | output | 1 | Combined interrupt |

## Verification
A pin change is due in the capture register and the flag three clock edges after it is driven. The bench drives the pin and counter from one stepping task on the falling clock edge. It reads results on the falling edge after the third rising edge and expects the counter value from two steps after the pin change. A clear takes effect one edge after the strobe. The interrupt follows the flags with no added register, so it is checked in the same sample as the flags.

// File: rtl/capPkg.sv
package capPkg;
  localparam int CAP_CHANNELS = 2;
  localparam int MODE_BITS    = 2;

  typedef enum logic [MODE_BITS-1:0] {
    MODE_OFF  = 2'd0,
    MODE_RISE = 2'd1,
    MODE_FALL = 2'd2,
    MODE_ANY  = 2'd3
  } edgeMode_t;

  typedef struct packed {
    logic [CAP_CHANNELS-1:0] capture;
  } capStrobe_t;
endpackage

// File: rtl/capEdgeCtrl.sv
module capEdgeCtrl
  import capPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [CAP_CHANNELS-1:0]            capPin,
  input  logic [CAP_CHANNELS*MODE_BITS-1:0]  modeSel,
  output capStrobe_t                         strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar ch = 0; ch < CAP_CHANNELS; ch++) begin : g_chan
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   prevLvl;
    logic                   lvl;
    logic                   riseSeen;
    logic                   fallSeen;
    edgeMode_t              chMode;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain <= '0;
        prevLvl   <= 1'b0;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], capPin[ch]};
        prevLvl   <= syncChain[LAST];
      end
    end

    assign lvl      = syncChain[LAST];
    assign riseSeen = lvl & ~prevLvl;
    assign fallSeen = ~lvl & prevLvl;
    assign chMode   = edgeMode_t'(modeSel[ch*MODE_BITS +: MODE_BITS]);

    always_comb begin
      unique case (chMode)
        MODE_RISE: strobe.capture[ch] = riseSeen;
        MODE_FALL: strobe.capture[ch] = fallSeen;
        MODE_ANY:  strobe.capture[ch] = riseSeen | fallSeen;
        default:   strobe.capture[ch] = 1'b0;
      endcase
    end

    // R5: disabled channel never strobes
    a_r5_off_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
      (chMode == MODE_OFF) |-> !strobe.capture[ch]);
    // R2: rising mode strobes only once the synchronized level is high
    a_r2_rise_level: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture[ch] && chMode == MODE_RISE) |-> (lvl && !prevLvl));
    // R3: falling mode strobes only once the synchronized level is low
    a_r3_fall_level: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture[ch] && chMode == MODE_FALL) |-> (!lvl && prevLvl));
  end
endmodule

// File: rtl/capDatapath.sv
module capDatapath
  import capPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  capStrobe_t                    strobe,
  input  logic [CNT_W-1:0]              counterVal,
  input  logic [CAP_CHANNELS-1:0]       flagClr,
  input  logic [CAP_CHANNELS-1:0]       irqEn,
  output logic [CAP_CHANNELS*CNT_W-1:0] capVal,
  output logic [CAP_CHANNELS-1:0]       capFlag,
  output logic                          irq
);
  for (genvar ch = 0; ch < CAP_CHANNELS; ch++) begin : g_chan
    logic [CNT_W-1:0] capReg;
    logic             flagReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capReg  <= '0;
        flagReg <= 1'b0;
      end else begin
        if (strobe.capture[ch]) capReg <= counterVal;
        if (strobe.capture[ch])  flagReg <= 1'b1;
        else if (flagClr[ch])    flagReg <= 1'b0;
      end
    end

    assign capVal[ch*CNT_W +: CNT_W] = capReg;
    assign capFlag[ch]               = flagReg;

    // R8: a capture always leaves the flag set, even against a clear
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capture[ch] |=> capFlag[ch]);
    // R8: a clear without a capture drops the flag
    a_r8_flag_clr: assert property (@(posedge clk) disable iff (!rstN)
      (flagClr[ch] && !strobe.capture[ch]) |=> !capFlag[ch]);
    // R5: register holds whenever no capture strobe arrives
    a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.capture[ch] |=> $stable(capVal[ch*CNT_W +: CNT_W]));
    // R9: a capture loads the counter value seen in that cycle
    a_r9_load: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capture[ch] |=> (capVal[ch*CNT_W +: CNT_W] == $past(counterVal)));
  end

  assign irq = |(capFlag & irqEn);
endmodule

// File: rtl/edgeCaptureUnit.sv
module edgeCaptureUnit
  import capPkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CAP_CHANNELS-1:0]       capPin,
  input  logic [CNT_W-1:0]              counterVal,
  input  logic [CAP_CHANNELS*MODE_BITS-1:0] modeSel,
  input  logic [CAP_CHANNELS-1:0]       flagClr,
  input  logic [CAP_CHANNELS-1:0]       irqEn,
  output logic [CAP_CHANNELS*CNT_W-1:0] capVal,
  output logic [CAP_CHANNELS-1:0]       capFlag,
  output logic                          irq
);
  capStrobe_t strobe;

  capEdgeCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .capPin  (capPin),
    .modeSel (modeSel),
    .strobe  (strobe)
  );

  capDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .counterVal (counterVal),
    .flagClr    (flagClr),
    .irqEn      (irqEn),
    .capVal     (capVal),
    .capFlag    (capFlag),
    .irq        (irq)
  );

  // R10: interrupt is raised only for an enabled, set flag; flags change only by capture or clear
  a_r10_irq_src: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((capFlag & irqEn) != '0));
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.capture == '0) && (flagClr == '0)) |=> $stable(capFlag));
endmodule

// File: tb/edgeCaptureUnit_bench.sv
module edgeCaptureUnit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;
  localparam int NVEC = 14;

  // vector: {channel, mode, pin level, capture expected}
  typedef struct packed {
    logic [0:0] ch;
    logic [1:0] mode;
    logic       lvl;
    logic       cap;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'd0, 2'd1, 1'b1, 1'b1},  // R2 rise captured
    '{1'd0, 2'd1, 1'b0, 1'b0},  // R2 fall ignored
    '{1'd0, 2'd2, 1'b1, 1'b0},  // R3 rise ignored
    '{1'd0, 2'd2, 1'b0, 1'b1},  // R3 fall captured
    '{1'd0, 2'd3, 1'b1, 1'b1},  // R4
    '{1'd0, 2'd3, 1'b0, 1'b1},  // R4
    '{1'd0, 2'd0, 1'b1, 1'b0},  // R5
    '{1'd0, 2'd0, 1'b0, 1'b0},  // R5
    '{1'd1, 2'd1, 1'b1, 1'b1},  // R6 channel 2 rise
    '{1'd1, 2'd2, 1'b0, 1'b1},  // R6 channel 2 fall
    '{1'd1, 2'd3, 1'b1, 1'b1},  // R4 channel 2
    '{1'd1, 2'd3, 1'b0, 1'b1},  // R4 channel 2
    '{1'd1, 2'd0, 1'b1, 1'b0},  // R5 channel 2
    '{1'd1, 2'd0, 1'b0, 1'b0}   // R5 channel 2
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] capPin = '0;
  logic [CNT_W-1:0] counterVal = '0;
  logic [3:0] modeSel = '0;
  logic [1:0] flagClr = '0;
  logic [1:0] irqEn = '0;
  logic [2*CNT_W-1:0] capVal;
  logic [1:0] capFlag;
  logic irq;

  int tests = 0;
  int fails = 0;
  logic [CNT_W-1:0] cnt = 32'h1000_0000;
  logic [CNT_W-1:0] expCap [2] = '{32'd0, 32'd0};

  always #(CLK_PERIOD/2) clk = ~clk;

  edgeCaptureUnit u_edgeCaptureUnit (
    .clk(clk), .rstN(rstN), .capPin(capPin), .counterVal(counterVal),
    .modeSel(modeSel), .flagClr(flagClr), .irqEn(irqEn),
    .capVal(capVal), .capFlag(capFlag), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
    cnt = cnt + 1;
    counterVal = cnt;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearFlags();
    flagClr = 2'b11;
    tick();
    flagClr = 2'b00;
    check(capFlag == 2'b00, "R8 clear", {62'd0, capFlag}, 64'd0);
  endtask

  // drive a pin change; returns the counter value expected to be captured
  task automatic edgeOn(input int ch, input logic lvl, output logic [CNT_W-1:0] want);
    tick();
    capPin[ch] = lvl;
    want = cnt + 2;
    tick();
    tick();
    tick();
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] want;
    repeat (3) tick();
    // R1 reset state
    check(capVal == '0, "R1 capVal", capVal, 64'd0);
    check(capFlag == 2'b00 && irq == 1'b0, "R1 flags/irq", {61'd0, irq, capFlag}, 64'd0);
    rstN = 1'b1;
    tick();

    irqEn = 2'b01;
    for (int i = 0; i < NVEC; i++) begin
      int ch;
      ch = int'(VECS[i].ch);
      modeSel = 4'(VECS[i].mode) << (2 * ch);
      edgeOn(ch, VECS[i].lvl, want);
      if (VECS[i].cap) expCap[ch] = want;
      // R7 value and timing, R2-R6 selection
      check(capVal[ch*CNT_W +: CNT_W] == expCap[ch], "R7 capture value",
            64'(capVal[ch*CNT_W +: CNT_W]), 64'(expCap[ch]));
      check(capFlag[ch] == VECS[i].cap && capFlag[1-ch] == 1'b0, "R6 flag select",
            64'(capFlag), 64'(VECS[i].cap) << ch);
      check(irq == (VECS[i].cap && ch == 0), "R10 irq", 64'(irq), 64'(VECS[i].cap && ch == 0));
      clearFlags();
    end

    // R7 flag not yet set one edge early
    modeSel = 4'b0001;
    tick();
    capPin[0] = 1'b1;
    want = cnt + 2;
    tick();
    tick();
    check(capFlag[0] == 1'b0, "R7 not early", 64'(capFlag[0]), 64'd0);
    tick();
    check(capFlag[0] == 1'b1 && capVal[CNT_W-1:0] == want, "R7 on time",
          64'(capVal[CNT_W-1:0]), 64'(want));

    // R9 overwrite while flag still set
    modeSel = 4'b0011;
    edgeOn(0, 1'b0, want);
    check(capFlag[0] == 1'b1 && capVal[CNT_W-1:0] == want, "R9 overwrite",
          64'(capVal[CNT_W-1:0]), 64'(want));

    // R8 capture wins over a coincident clear
    tick();
    capPin[0] = 1'b1;
    want = cnt + 2;
    tick();
    tick();
    flagClr = 2'b01;
    tick();
    flagClr = 2'b00;
    check(capFlag[0] == 1'b1 && capVal[CNT_W-1:0] == want, "R8 set wins",
          {31'd0, capFlag[0], capVal[CNT_W-1:0]}, {31'd1, want});
    clearFlags();

    // R10 enable gating per channel
    irqEn = 2'b10;
    modeSel = 4'b1111;
    edgeOn(0, 1'b0, want);
    check(capFlag == 2'b01 && irq == 1'b0, "R10 masked", 64'(irq), 64'd0);
    edgeOn(1, 1'b1, want);
    check(capFlag == 2'b11 && irq == 1'b1, "R10 enabled", 64'(irq), 64'd1);
    flagClr = 2'b10;
    tick();
    flagClr = 2'b00;
    check(capFlag == 2'b01 && irq == 1'b0, "R10 cleared", 64'(irq), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule